// File: doc/BRIEF.md
# Clock Output Gating and Power Sequencing Controller

This block sits between a clock generator's free-running divided clocks and its output pins. For every output it decides each cycle whether the clock toggles, is held driven low, or has its driver switched off (tri-stated). The decision combines three things: a power-good pin whose low level means power-down, output-enable pins that each cover one output or one group of outputs, and per-output enable bits from the configuration registers. While the part is powered down, two configuration bits choose whether each differential output (the processor clock and the dot clock) is driven low or left at high impedance.

A small state machine on the reference clock sequences the restart after power-good rises. Its states are `ST_OFF` (powered down), `ST_START` (start-up wait), `ST_HOLD` (all outputs except the processor clock may run) and `ST_RUN` (every output may run). `ST_OFF` moves to `ST_START` when the synchronised power-good is high. `ST_START` moves to `ST_HOLD` after `START_CYCLES` reference cycles. `ST_HOLD` moves to `ST_RUN` after a further `CPU_CYCLES` cycles. Any state returns to `ST_OFF` as soon as the synchronised power-good is low. Each output has a gate cell that samples its enable request on falling edges of its own source clock, so an output only ever emits whole high pulses.

Top module: `clkout_gate_ctrl`

## Requirements
- R1: The power-good pin passes through two reference-clock flops. Once the second flop holds a low level, the sequencer is in `ST_OFF` on the next reference edge. In `ST_OFF` every clock output stops, whatever the enable pins and enable bits say, and this also holds while the block is in reset.
- R2: After power-good is seen high, every output other than the processor clock stays stopped for `START_CYCLES` reference cycles (`ST_START`). The outputs are then allowed to run.
- R3: The processor clock stays stopped for a further `CPU_CYCLES` reference cycles (`ST_HOLD`). It is never allowed while the other outputs are still held.
- R4: Once the non-processor outputs are allowed, the dot clock runs only when both its enable pin and its enable bit are 1. With its pin at 0 its driver-enable output is 0 (tri-state). With the pin at 1 and the bit at 0 it is driven low (driver-enable 1).
- R5: In `ST_RUN`, the processor clock follows the same rule as the dot clock, using its own pin and its own enable bit.
- R6: While a differential output is not yet allowed (the processor clock in `ST_OFF`, `ST_START` and `ST_HOLD`; the dot clock in `ST_OFF` and `ST_START`), its clock is low. Its driver-enable is the inverse of its power-down bit: 0 means driven, 1 means high impedance.
- R7: Network output k runs when the non-processor outputs are allowed, enable bit k is 1, and its group pin is 1. The low group pin covers outputs 0 to NET_N/2-1 and the high group pin covers the rest. A disabled network output is held low.
- R8: The mid-rate output, each reference output i and the slow output run only while their own enable bit is 1 and the non-processor outputs are allowed. Otherwise they are held low.
- R9: Each gated clock is its source clock ANDed with an enable. That enable is taken from the request through SYNC_STAGES falling-edge flops of the source clock, so a gated output is always low while its source is low. A request present at falling edge j shows in the high phase that follows rising edge j+SYNC_STAGES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; runs the sequencer and is the source for the reference outputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_src | input | 1 | Free-running processor clock source |
| dot_src | input | 1 | Free-running dot clock source |
| net_src | input | 1 | Free-running network clock source |
| mid_src | input | 1 | Free-running mid-rate clock source |
| slow_src | input | 1 | Free-running slow clock source |
| pwrgd | input | 1 | Power-good pin; low requests power-down |
| oe_cpu_pin | input | 1 | Processor clock enable pin; low tri-states it |
| oe_dot_pin | input | 1 | Dot clock enable pin; low tri-states it |
| oe_net_lo_pin | input | 1 | Enable pin for the lower network group |
| oe_net_hi_pin | input | 1 | Enable pin for the upper network group |
| cfg_cpu_en | input | 1 | Processor clock enable bit |
| cfg_dot_en | input | 1 | Dot clock enable bit |
| cfg_cpu_pd_hiz | input | 1 | Processor clock power-down mode, 1 = high impedance |
| cfg_dot_pd_hiz | input | 1 | Dot clock power-down mode, 1 = high impedance |
| cfg_net_en | input | NET_N | Per-output network enable bits, bit k for output k |
| cfg_mid_en | input | 1 | Mid-rate output enable bit |
| cfg_ref_en | input | REF_N | Per-output reference enable bits |
| cfg_slow_en | input | 1 | Slow output enable bit |
| cpu_clk_o | output | 1 | Gated processor clock |
| cpu_oe_o | output | 1 | Processor clock driver enable |
| dot_clk_o | output | 1 | Gated dot clock |
| dot_oe_o | output | 1 | Dot clock driver enable |
| net_clk_o | output | NET_N | Gated network clocks |
| mid_clk_o | output | 1 | Gated mid-rate clock |
| ref_clk_o | output | REF_N | Gated reference clocks |
| slow_clk_o | output | 1 | Gated slow clock |

## Verification
Two events can fall in the same reference cycle: a power-good drop, and the last count of the start-up wait or of the processor-clock hold. An enable pin may also toggle in that same cycle. The bench provokes this by releasing power-good and dropping it again after every offset from one to fourteen cycles, flipping the processor enable pin at the same moment. Each time, a behavioural model built on a saturating count of consecutive power-good samples predicts which outputs must run, and the gated clocks and driver enables are compared against it on every edge.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_START = 2'd1,
        ST_HOLD  = 2'd2,
        ST_RUN   = 2'd3
    } pwr_state_e;
endpackage

// File: rtl/clkgate_pwr_seq.sv
module clkgate_pwr_seq
    import clkgate_pkg::*;
#(
    parameter int START_CYCLES = 62500,
    parameter int CPU_CYCLES   = 7500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwrgd_i,
    output logic rest_ok_o,
    output logic cpu_ok_o
);
    localparam int MAXC = (START_CYCLES > CPU_CYCLES) ? START_CYCLES : CPU_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] START_LAST = CW'(START_CYCLES - 1);
    localparam logic [CW-1:0] CPU_LAST   = CW'(CPU_CYCLES - 1);

    logic          pg_s1, pg_s2;
    pwr_state_e    state, state_nxt;
    logic [CW-1:0] cnt;

    // power-good synchroniser
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_s1 <= 1'b0;
            pg_s2 <= 1'b0;
        end else begin
            pg_s1 <= pwrgd_i;
            pg_s2 <= pg_s1;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF:   if (pg_s2) state_nxt = ST_START;
            ST_START: if (!pg_s2) state_nxt = ST_OFF;
                      else if (cnt == START_LAST) state_nxt = ST_HOLD;
            ST_HOLD:  if (!pg_s2) state_nxt = ST_OFF;
                      else if (cnt == CPU_LAST) state_nxt = ST_RUN;
            ST_RUN:   if (!pg_s2) state_nxt = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

    // wait counter, cleared on every transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  cnt <= '0;
        else if (state_nxt != state)                 cnt <= '0;
        else if (state == ST_START || state == ST_HOLD) cnt <= cnt + CW'(1);
    end

    // outputs
    always_comb begin
        rest_ok_o = (state == ST_HOLD) || (state == ST_RUN);
        cpu_ok_o  = (state == ST_RUN);
    end

    assert_pd_forces_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_s2 |=> (state == ST_OFF));

    assert_start_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && $past(state) != ST_HOLD) |->
        ($past(state) == ST_START && $past(cnt) == START_LAST));

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(MAXC));

    assert_run_after_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && $past(state) != ST_RUN) |->
        ($past(state) == ST_HOLD && $past(cnt) == CPU_LAST));
endmodule

// File: rtl/clkgate_cell.sv
module clkgate_cell #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic en_req,
    output logic gclk_o
);
    logic en_q;

    generate
        if (SYNC_STAGES <= 1) begin : g_single
            always_ff @(negedge clk_src or negedge rst_n) begin
                if (!rst_n) en_q <= 1'b0;
                else        en_q <= en_req;
            end
        end else begin : g_chain
            logic [SYNC_STAGES-1:0] sh;
            always_ff @(negedge clk_src or negedge rst_n) begin
                if (!rst_n) sh <= '0;
                else        sh <= {sh[SYNC_STAGES-2:0], en_req};
            end
            assign en_q = sh[SYNC_STAGES-1];
        end
    endgenerate

    // enable only moves on falling edges, so high pulses stay whole
    assign gclk_o = clk_src & en_q;
endmodule

// File: rtl/clkout_gate_ctrl.sv
module clkout_gate_ctrl #(
    parameter int NET_N        = 8,
    parameter int REF_N        = 2,
    parameter int SYNC_STAGES  = 2,
    parameter int START_CYCLES = 62500,
    parameter int CPU_CYCLES   = 7500
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             cpu_src,
    input  logic             dot_src,
    input  logic             net_src,
    input  logic             mid_src,
    input  logic             slow_src,
    input  logic             pwrgd,
    input  logic             oe_cpu_pin,
    input  logic             oe_dot_pin,
    input  logic             oe_net_lo_pin,
    input  logic             oe_net_hi_pin,
    input  logic             cfg_cpu_en,
    input  logic             cfg_dot_en,
    input  logic             cfg_cpu_pd_hiz,
    input  logic             cfg_dot_pd_hiz,
    input  logic [NET_N-1:0] cfg_net_en,
    input  logic             cfg_mid_en,
    input  logic [REF_N-1:0] cfg_ref_en,
    input  logic             cfg_slow_en,
    output logic             cpu_clk_o,
    output logic             cpu_oe_o,
    output logic             dot_clk_o,
    output logic             dot_oe_o,
    output logic [NET_N-1:0] net_clk_o,
    output logic             mid_clk_o,
    output logic [REF_N-1:0] ref_clk_o,
    output logic             slow_clk_o
);
    localparam int NET_LO = NET_N / 2;

    logic             rest_ok, cpu_ok;
    logic             cpu_req, dot_req, mid_req, slow_req;
    logic [NET_N-1:0] net_req;
    logic [REF_N-1:0] ref_req;

    clkgate_pwr_seq #(
        .START_CYCLES(START_CYCLES),
        .CPU_CYCLES  (CPU_CYCLES)
    ) u_seq (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .pwrgd_i  (pwrgd),
        .rest_ok_o(rest_ok),
        .cpu_ok_o (cpu_ok)
    );

    always_comb begin
        cpu_req  = cpu_ok  & oe_cpu_pin & cfg_cpu_en;
        dot_req  = rest_ok & oe_dot_pin & cfg_dot_en;
        mid_req  = rest_ok & cfg_mid_en;
        slow_req = rest_ok & cfg_slow_en;
        for (int k = 0; k < NET_N; k++)
            net_req[k] = rest_ok & cfg_net_en[k] &
                         ((k < NET_LO) ? oe_net_lo_pin : oe_net_hi_pin);
        for (int i = 0; i < REF_N; i++)
            ref_req[i] = rest_ok & cfg_ref_en[i];
        cpu_oe_o = cpu_ok  ? oe_cpu_pin : ~cfg_cpu_pd_hiz;
        dot_oe_o = rest_ok ? oe_dot_pin : ~cfg_dot_pd_hiz;
    end

    clkgate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cpu (
        .clk_src(cpu_src), .rst_n(rst_n), .en_req(cpu_req), .gclk_o(cpu_clk_o));
    clkgate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_dot (
        .clk_src(dot_src), .rst_n(rst_n), .en_req(dot_req), .gclk_o(dot_clk_o));
    clkgate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_mid (
        .clk_src(mid_src), .rst_n(rst_n), .en_req(mid_req), .gclk_o(mid_clk_o));
    clkgate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_slow (
        .clk_src(slow_src), .rst_n(rst_n), .en_req(slow_req), .gclk_o(slow_clk_o));

    generate
        for (genvar k = 0; k < NET_N; k++) begin : g_net
            clkgate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_net (
                .clk_src(net_src), .rst_n(rst_n), .en_req(net_req[k]), .gclk_o(net_clk_o[k]));
        end
        for (genvar i = 0; i < REF_N; i++) begin : g_ref
            clkgate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_ref (
                .clk_src(ref_clk), .rst_n(rst_n), .en_req(ref_req[i]), .gclk_o(ref_clk_o[i]));
        end
    endgenerate

    assert_cpu_after_rest_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        cpu_ok |-> rest_ok);

    assert_pd_drive_mode_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !rest_ok |-> (dot_oe_o == !cfg_dot_pd_hiz && cpu_oe_o == !cfg_cpu_pd_hiz));
endmodule

// File: tb/clkout_gate_ctrl_test.sv
module clkout_gate_ctrl_test;
    localparam int S = 6;
    localparam int C = 4;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, pwrgd = 1'b0;
    logic oe_cpu_pin = 1, oe_dot_pin = 1, oe_lo = 1, oe_hi = 1;
    logic cfg_cpu_en = 1, cfg_dot_en = 1, cpu_hiz = 0, dot_hiz = 0;
    logic [7:0] cfg_net_en = 8'hFF;
    logic cfg_mid_en = 1, cfg_slow_en = 1;
    logic [1:0] cfg_ref_en = 2'b11;

    logic cpu_clk_o, cpu_oe_o, dot_clk_o, dot_oe_o, mid_clk_o, slow_clk_o;
    logic [7:0] net_clk_o;
    logic [1:0] ref_clk_o;

    clkout_gate_ctrl #(.NET_N(8), .REF_N(2), .SYNC_STAGES(SYNC),
                       .START_CYCLES(S), .CPU_CYCLES(C)) uut (
        .ref_clk(clk), .rst_n(rst_n), .cpu_src(clk), .dot_src(clk), .net_src(clk),
        .mid_src(clk), .slow_src(clk), .pwrgd(pwrgd), .oe_cpu_pin(oe_cpu_pin),
        .oe_dot_pin(oe_dot_pin), .oe_net_lo_pin(oe_lo), .oe_net_hi_pin(oe_hi),
        .cfg_cpu_en(cfg_cpu_en), .cfg_dot_en(cfg_dot_en), .cfg_cpu_pd_hiz(cpu_hiz),
        .cfg_dot_pd_hiz(dot_hiz), .cfg_net_en(cfg_net_en), .cfg_mid_en(cfg_mid_en),
        .cfg_ref_en(cfg_ref_en), .cfg_slow_en(cfg_slow_en), .cpu_clk_o(cpu_clk_o),
        .cpu_oe_o(cpu_oe_o), .dot_clk_o(dot_clk_o), .dot_oe_o(dot_oe_o),
        .net_clk_o(net_clk_o), .mid_clk_o(mid_clk_o), .ref_clk_o(ref_clk_o),
        .slow_clk_o(slow_clk_o));

    int compared = 0, mismatched = 0;

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model: count of consecutive high power-good samples, seen two edges late
    int   up = 0;
    logic pgq[$] = '{1'b0, 1'b0};
    always @(posedge clk) begin
        if (!rst_n) begin
            up = 0;
            pgq = '{1'b0, 1'b0};
        end else begin
            logic seen;
            seen = pgq[0];
            void'(pgq.pop_front());
            pgq.push_back(pwrgd);
            if (!seen) up = 0;
            else if (up < 1000000) up = up + 1;
        end
    end

    function automatic bit rest_allowed();
        return up >= S + 1;
    endfunction
    function automatic bit cpu_allowed();
        return up >= S + C + 1;
    endfunction

    // requests as seen at each falling edge: {cpu, dot, net[7:0], mid, ref[1:0], slow}
    logic [13:0] reqq[$];
    always @(negedge clk) begin
        logic [13:0] r;
        logic [7:0]  nr;
        r = '0;
        if (rst_n) begin
            for (int k = 0; k < 8; k++)
                nr[k] = rest_allowed() & cfg_net_en[k] & (k < 4 ? oe_lo : oe_hi);
            r = {cpu_allowed() & oe_cpu_pin & cfg_cpu_en,
                 rest_allowed() & oe_dot_pin & cfg_dot_en, nr,
                 rest_allowed() & cfg_mid_en, {2{rest_allowed()}} & cfg_ref_en,
                 rest_allowed() & cfg_slow_en};
        end
        reqq.push_back(r);
        if (reqq.size() > 8) void'(reqq.pop_front());
    end

    // compare in every high phase
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            logic [13:0] e;
            string ct, rt;
            e = (reqq.size() >= SYNC) ? reqq[reqq.size() - SYNC] : '0;
            ct = (up == 0) ? "R1" : (up <= S + C) ? "R3" : "R5";
            rt = (up == 0) ? "R1" : (up <= S) ? "R2" : "";
            chk({ct, " cpu clock"}, 16'(cpu_clk_o), 16'(e[13]));
            chk({(rt == "") ? "R4" : rt, " dot clock"}, 16'(dot_clk_o), 16'(e[12]));
            chk({(rt == "") ? "R7" : rt, " network clocks"}, 16'(net_clk_o), 16'(e[11:4]));
            chk({(rt == "") ? "R8" : rt, " single-ended clocks"},
                16'({mid_clk_o, ref_clk_o, slow_clk_o}), 16'(e[3:0]));
            chk(cpu_allowed() ? "R5 cpu oe" : "R6 cpu oe", 16'(cpu_oe_o),
                16'(cpu_allowed() ? oe_cpu_pin : !cpu_hiz));
            chk(rest_allowed() ? "R4 dot oe" : "R6 dot oe", 16'(dot_oe_o),
                16'(rest_allowed() ? oe_dot_pin : !dot_hiz));
        end
    end

    // low phase: every gated output must be low
    always @(negedge clk) begin
        #2;
        chk("R9 low phase", 16'({cpu_clk_o, dot_clk_o, net_clk_o, mid_clk_o, ref_clk_o, slow_clk_o}),
            16'h0000);
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        #100000;
        mismatched++;
        $display("FAIL watchdog expired at %0t", $time);
        summary();
        $finish;
    end

    initial begin
        step(3);
        // R1: reset state, everything held, differential outputs driven
        chk("R1 reset clocks", 16'({cpu_clk_o, dot_clk_o, net_clk_o, mid_clk_o, ref_clk_o, slow_clk_o}),
            16'h0000);
        chk("R1 reset oe", 16'({cpu_oe_o, dot_oe_o}), 16'b11);
        rst_n = 1'b1;
        step(5);
        pwrgd = 1'b1;                      // R2/R3 start-up sequence
        step(25);
        oe_dot_pin = 0; step(4); oe_dot_pin = 1; step(2);       // R4 tri-state
        cfg_dot_en = 0; step(4); cfg_dot_en = 1; step(2);       // R4 driven low
        oe_cpu_pin = 0; step(4); oe_cpu_pin = 1; step(2);       // R5
        cfg_cpu_en = 0; step(4); cfg_cpu_en = 1; step(2);
        oe_lo = 0; step(6); oe_lo = 1; oe_hi = 0; step(6); oe_hi = 1;   // R7 groups
        cfg_net_en = 8'h5A; step(6); cfg_net_en = 8'h81; step(6); cfg_net_en = 8'hFF;
        cfg_mid_en = 0; step(4); cfg_ref_en = 2'b01; step(4);           // R8
        cfg_ref_en = 2'b10; cfg_slow_en = 0; step(4);
        cfg_mid_en = 1; cfg_ref_en = 2'b11; cfg_slow_en = 1; step(4);
        // R6: power-down with high impedance chosen, pins toggled meanwhile (R1)
        cpu_hiz = 1; dot_hiz = 1; pwrgd = 0; step(6);
        oe_cpu_pin = 0; oe_dot_pin = 0; step(3); oe_cpu_pin = 1; oe_dot_pin = 1;
        dot_hiz = 0; step(4);
        pwrgd = 1; step(25);
        // power-down falling on every wait boundary, cpu pin flipped in the same cycle
        for (int off = 1; off <= 14; off++) begin
            pwrgd = 0; step(6);
            pwrgd = 1; step(off);
            pwrgd = 0; oe_cpu_pin = ~oe_cpu_pin; step(6);
            oe_cpu_pin = 1; pwrgd = 1; step(S + C + 6);
        end
        // one-cycle power-good glitch
        pwrgd = 0; step(1); pwrgd = 1; step(20);
        summary();
        $finish;
    end
endmodule